// File: doc/BRIEF.md
# Split-Width Interrupt Controller Register File

This block is the software-visible register store for a 64-source interrupt controller. Each per-source control vector (mask, edge select, message enable, polarity and in-service) is 64 bits wide. Software reaches each vector as two 32-bit words. Two per-source byte tables, one holding route codes and one holding vector numbers, are reached one byte at a time. Writes to the mask and clear words also emit one-cycle strobes. The dispatch logic downstream uses these strobes to re-evaluate pending sources.

Requests arrive on a single-beat port. A request carries valid, write, a 2-bit size code, an address and 64 bits of write data. Only address bits 11:0 are decoded. Read data returns one cycle after the request. The stored vectors are also driven out as plain 64-bit outputs for the dispatch logic.

Word map (offsets, low word then high word): identification 0x000/0x004, mask 0x020/0x024, message enable 0x040/0x044, edge select 0x060/0x064, clear 0x080/0x084, in-service status 0x3A0/0x3A4, polarity 0x3E0/0x3E4. Offsets 0x0C0 to 0x0CC are reserved automatic-control words. Route table entries sit at 0x100+i and vector table entries at 0x200+i, for i = 0 to 63.

Top module: `intc_regfile`

## Requirements
- R1: Only req_addr[11:0] selects a register. An access whose upper address bits differ but whose low 12 bits match reaches the same register.
- R2: A word write (req_size = 2'b10) to the low word of a vector replaces bits 31:0 and keeps bits 63:32. A word write to the high word (low word offset + 4) replaces bits 63:32 and keeps bits 31:0.
- R3: A double-word access (req_size = 2'b11) at offset A acts as a word access at A using data bits 31:0, plus a word access at A+4 using data bits 63:32. A double-word read returns word A in bits 31:0 and word A+4 in bits 63:32.
- R4: The route and vector tables hold 64 entries of 8 bits. They respond only to byte accesses (req_size = 2'b00), which write req_wdata[7:0] and read into rsp_rdata[7:0] with the upper bits zero. Table offsets at index 64 or above read zero and ignore writes. Word accesses to a table read zero and change nothing, and byte accesses to a word register change nothing.
- R5: After reset, the mask is all ones. Message enable, edge select, polarity and in-service are zero. Every route entry is 1 and every vector entry is 0.
- R6: Identification word 0x000 reads 32'h0001_0700 and word 0x004 reads 32'h003F_0000. The reserved words 0x0C0 to 0x0CC and any unmapped offset read zero, and writes to them change nothing.
- R7: In the cycle after a mask write, unmask_stb carries the bits of the written word that went from 1 to 0, and mask_stb carries the bits that went from 0 to 1. Both sit at the word's own position (shifted up by 32 for the high word). Each strobe lasts one cycle.
- R8: In the cycle after a write to a clear word, clr_stb carries the written bits ANDed with edge_sel, placed in that word's half. The same bits leave in_service. A clear word stores nothing and reads zero.
- R9: A write to a status word sets that half of in_service. A read of a status word returns in_service AND NOT int_mask for that half.
- R10: A read request gives rsp_valid and its data in the following cycle. A write request gives no rsp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 byte, 10 word, 11 double word; 01 is ignored |
| req_addr | input | ADDR_W | Byte address; bits 11:0 decoded |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data |
| unmask_stb | output | 64 | Sources newly unmasked, one cycle |
| mask_stb | output | 64 | Sources newly masked, one cycle |
| clr_stb | output | 64 | Edge sources cleared, one cycle |
| int_mask | output | 64 | Mask vector |
| edge_sel | output | 64 | Edge-select vector |
| msg_en | output | 64 | Message-enable vector |
| polarity | output | 64 | Polarity vector |
| in_service | output | 64 | In-service vector |

## Verification
A wrong merge of the two words of a vector appears on the vector's output port in the first cycle after the write, because the kept half changes. A wrong strobe computation appears in the cycle after the write as strobe bits that disagree with int_mask, edge_sel or in_service in that same cycle. The table and decode faults only show on a later read, one cycle after the read request. The tests therefore follow each table or decode write with a read of both the target entry and a neighbouring entry.

// File: rtl/intc_regfile_pkg.sv
package intc_regfile_pkg;

    localparam int SRC_N     = 64;
    localparam int HALF_W    = SRC_N / 2;
    localparam int WORD_W    = SRC_N;
    localparam int OFF_W     = 12;
    localparam int TBL_DEPTH = 64;
    localparam int ENT_W     = 8;
    localparam int IDX_W     = $clog2(TBL_DEPTH);

    // split vectors held by the register file
    localparam int NREG      = 5;
    localparam int RI_MASK   = 0;
    localparam int RI_MSGEN  = 1;
    localparam int RI_EDGE   = 2;
    localparam int RI_POL    = 3;
    localparam int RI_ISR    = 4;

    typedef logic [OFF_W-1:0] off_t;

    localparam off_t OFF_ID0    = 12'h000;
    localparam off_t OFF_ID1    = 12'h004;
    localparam off_t OFF_CLR    = 12'h080;
    localparam off_t OFF_ROUTE  = 12'h100;
    localparam off_t OFF_VEC    = 12'h200;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_HALF  = 2'b01,
        SZ_WORD  = 2'b10,
        SZ_DWORD = 2'b11
    } size_e;

    // low-word offset of each split vector
    function automatic off_t reg_lo_off(input int idx);
        case (idx)
            RI_MASK:  return 12'h020;
            RI_MSGEN: return 12'h040;
            RI_EDGE:  return 12'h060;
            RI_POL:   return 12'h3E0;
            default:  return 12'h3A0;
        endcase
    endfunction

    // does one of the (up to two) word beats of an access land on off
    function automatic logic beat_hit(input off_t a0, input logic dbl, input off_t off);
        return (a0 == off) || (dbl && ((a0 + off_t'(4)) == off));
    endfunction

    // data carried by the beat that lands on off
    function automatic logic [HALF_W-1:0] beat_data(input off_t a0,
                                                   input logic [WORD_W-1:0] w,
                                                   input off_t off);
        return (a0 == off) ? w[HALF_W-1:0] : w[WORD_W-1:HALF_W];
    endfunction

    typedef struct packed {
        logic              rsp_valid;
        logic [WORD_W-1:0] rdata;
        logic [WORD_W-1:0] unmask;
        logic [WORD_W-1:0] mask;
        logic [WORD_W-1:0] clr;
    } out_st_t;

endpackage

// File: rtl/intc_split_reg.sv
module intc_split_reg #(
    parameter int                    HALF_W  = 32,
    parameter logic [2*HALF_W-1:0]   RST_VAL = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          we,
    input  logic [2*HALF_W-1:0] wd,
    input  logic [2*HALF_W-1:0] clr,
    output logic [2*HALF_W-1:0] q
);

    logic [2*HALF_W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        for (int h = 0; h < 2; h++) begin
            if (we[h]) val_d[h*HALF_W +: HALF_W] = wd[h*HALF_W +: HALF_W];
        end
        val_d = val_d & ~clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= RST_VAL;
        else        val_q <= val_d;
    end

    assign q = val_q;

endmodule

// File: rtl/intc_byte_table.sv
module intc_byte_table #(
    parameter int               DEPTH   = 64,
    parameter int               ENT_W   = 8,
    parameter logic [ENT_W-1:0] RST_VAL = '0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [$clog2(DEPTH)-1:0]   widx,
    input  logic [ENT_W-1:0]           wdata,
    input  logic [$clog2(DEPTH)-1:0]   ridx,
    output logic [ENT_W-1:0]           rdata
);

    logic [ENT_W-1:0] mem_d [DEPTH];
    logic [ENT_W-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        if (we) mem_d[widx] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= RST_VAL;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rdata = mem_q[ridx];

endmodule

// File: rtl/intc_regfile.sv
module intc_regfile
    import intc_regfile_pkg::*;
#(
    parameter int          ADDR_W   = 32,
    parameter logic [31:0] ID_WORD0 = 32'h0001_0700,
    parameter logic [31:0] ID_WORD1 = 32'(SRC_N - 1) << 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic [WORD_W-1:0] unmask_stb,
    output logic [WORD_W-1:0] mask_stb,
    output logic [WORD_W-1:0] clr_stb,
    output logic [WORD_W-1:0] int_mask,
    output logic [WORD_W-1:0] edge_sel,
    output logic [WORD_W-1:0] msg_en,
    output logic [WORD_W-1:0] polarity,
    output logic [WORD_W-1:0] in_service
);

    // ---------------- access decode ----------------
    off_t a0;
    logic wr, rd, wacc, dbl, bacc;
    logic addr_unused;

    assign a0          = req_addr[OFF_W-1:0];
    assign addr_unused = ^req_addr[ADDR_W-1:OFF_W];
    assign wr          = req_valid &  req_write;
    assign rd          = req_valid & ~req_write;
    assign dbl         = (req_size == SZ_DWORD);
    assign wacc        = (req_size == SZ_WORD) || dbl;
    assign bacc        = (req_size == SZ_BYTE);

    // ---------------- byte tables ----------------
    off_t rt_rel, vc_rel;
    logic rt_hit, vc_hit;
    logic [ENT_W-1:0] rt_rd, vc_rd;

    assign rt_rel = a0 - OFF_ROUTE;
    assign vc_rel = a0 - OFF_VEC;
    assign rt_hit = bacc && (rt_rel < off_t'(TBL_DEPTH));
    assign vc_hit = bacc && (vc_rel < off_t'(TBL_DEPTH));

    intc_byte_table #(.DEPTH(TBL_DEPTH), .ENT_W(ENT_W), .RST_VAL(ENT_W'(1))) u_route (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr && rt_hit),
        .widx  (rt_rel[IDX_W-1:0]),
        .wdata (req_wdata[ENT_W-1:0]),
        .ridx  (rt_rel[IDX_W-1:0]),
        .rdata (rt_rd)
    );

    intc_byte_table #(.DEPTH(TBL_DEPTH), .ENT_W(ENT_W), .RST_VAL(ENT_W'(0))) u_vector (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr && vc_hit),
        .widx  (vc_rel[IDX_W-1:0]),
        .wdata (req_wdata[ENT_W-1:0]),
        .ridx  (vc_rel[IDX_W-1:0]),
        .rdata (vc_rd)
    );

    // ---------------- split vectors ----------------
    logic [NREG-1:0][1:0]        we_r;
    logic [NREG-1:0][WORD_W-1:0] wd_r;
    logic [NREG-1:0][WORD_W-1:0] clr_r;
    logic [NREG-1:0][WORD_W-1:0] q_r;

    for (genvar g = 0; g < NREG; g++) begin : g_vec
        localparam logic [WORD_W-1:0] RV = (g == RI_MASK) ? {WORD_W{1'b1}} : {WORD_W{1'b0}};
        intc_split_reg #(.HALF_W(HALF_W), .RST_VAL(RV)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (we_r[g]),
            .wd    (wd_r[g]),
            .clr   (clr_r[g]),
            .q     (q_r[g])
        );
    end

    function automatic logic [HALF_W-1:0] word_read(input off_t off,
                                                   input logic [NREG-1:0][WORD_W-1:0] r);
        logic [WORD_W-1:0] stat;
        logic [HALF_W-1:0] rv;
        stat = r[RI_ISR] & ~r[RI_MASK];
        rv   = '0;
        if (off == OFF_ID0) rv = ID_WORD0;
        if (off == OFF_ID1) rv = ID_WORD1;
        for (int g = 0; g < NREG; g++) begin
            for (int h = 0; h < 2; h++) begin
                if (off == reg_lo_off(g) + off_t'(4 * h)) begin
                    rv = (g == RI_ISR) ? stat[h*HALF_W +: HALF_W] : r[g][h*HALF_W +: HALF_W];
                end
            end
        end
        return rv;
    endfunction

    // ---------------- next-state ----------------
    out_st_t           out_d, out_q;
    logic [WORD_W-1:0] clr_bits, clr_eff;
    off_t              cur_off;

    always_comb begin
        out_d    = '0;
        we_r     = '0;
        wd_r     = '0;
        clr_r    = '0;
        clr_bits = '0;
        cur_off  = '0;

        for (int g = 0; g < NREG; g++) begin
            for (int h = 0; h < 2; h++) begin
                cur_off = reg_lo_off(g) + off_t'(4 * h);
                if (wr && wacc && beat_hit(a0, dbl, cur_off)) begin
                    we_r[g][h] = 1'b1;
                    wd_r[g][h*HALF_W +: HALF_W] = beat_data(a0, req_wdata, cur_off);
                end
            end
        end

        for (int h = 0; h < 2; h++) begin
            cur_off = OFF_CLR + off_t'(4 * h);
            if (wr && wacc && beat_hit(a0, dbl, cur_off)) begin
                clr_bits[h*HALF_W +: HALF_W] = beat_data(a0, req_wdata, cur_off);
            end
        end
        clr_eff       = clr_bits & q_r[RI_EDGE];
        clr_r[RI_ISR] = clr_eff;
        out_d.clr     = clr_eff;

        for (int h = 0; h < 2; h++) begin
            if (we_r[RI_MASK][h]) begin
                out_d.unmask[h*HALF_W +: HALF_W] =  q_r[RI_MASK][h*HALF_W +: HALF_W]
                                                 & ~wd_r[RI_MASK][h*HALF_W +: HALF_W];
                out_d.mask[h*HALF_W +: HALF_W]   = ~q_r[RI_MASK][h*HALF_W +: HALF_W]
                                                 &  wd_r[RI_MASK][h*HALF_W +: HALF_W];
            end
        end

        out_d.rsp_valid = rd;
        if (rd) begin
            if (rt_hit) begin
                out_d.rdata[ENT_W-1:0] = rt_rd;
            end else if (vc_hit) begin
                out_d.rdata[ENT_W-1:0] = vc_rd;
            end else if (wacc) begin
                out_d.rdata[HALF_W-1:0] = word_read(a0, q_r);
                if (dbl) out_d.rdata[WORD_W-1:HALF_W] = word_read(a0 + off_t'(4), q_r);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rsp_valid  = out_q.rsp_valid;
    assign rsp_rdata  = out_q.rdata;
    assign unmask_stb = out_q.unmask;
    assign mask_stb   = out_q.mask;
    assign clr_stb    = out_q.clr;
    assign int_mask   = q_r[RI_MASK];
    assign edge_sel   = q_r[RI_EDGE];
    assign msg_en     = q_r[RI_MSGEN];
    assign polarity   = q_r[RI_POL];
    assign in_service = q_r[RI_ISR];

endmodule

// File: rtl/intc_regfile_chk.sv
module intc_regfile_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic        rsp_valid,
    input logic [63:0] unmask_stb,
    input logic [63:0] mask_stb,
    input logic [63:0] clr_stb,
    input logic [63:0] int_mask,
    input logic [63:0] edge_sel,
    input logic [63:0] in_service
);

    // R7: a newly masked source is masked in the register in the strobe cycle
    a_r7_mask_stb_in_reg: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_stb & ~int_mask) == 64'd0);

    // R7: a newly unmasked source is clear in the register in the strobe cycle
    a_r7_unmask_stb_in_reg: assert property (@(posedge clk) disable iff (!rst_n)
        (unmask_stb & int_mask) == 64'd0);

    // R8: clear strobes only name edge-selected sources
    a_r8_clr_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb & ~edge_sel) == 64'd0);

    // R8: cleared sources have left in-service
    a_r8_clr_drops_isr: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb & in_service) == 64'd0);

    // R10: a response follows a read request
    a_r10_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write));

    // R10: a write request gets no response
    a_r10_no_rsp_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_write) |-> !rsp_valid);

endmodule

bind intc_regfile intc_regfile_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .rsp_valid  (rsp_valid),
    .unmask_stb (unmask_stb),
    .mask_stb   (mask_stb),
    .clr_stb    (clr_stb),
    .int_mask   (int_mask),
    .edge_sel   (edge_sel),
    .in_service (in_service)
);

// File: tb/tb_intc_regfile.sv
module tb_intc_regfile;

    localparam logic [1:0] B = 2'b00, W = 2'b10, D = 2'b11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_size = 2'b10;
    logic [31:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata, unmask_stb, mask_stb, clr_stb;
    logic [63:0] int_mask, edge_sel, msg_en, polarity, in_service;

    int checks = 0, errors = 0;
    logic        r_rsp;
    logic [63:0] r_rdata, r_unmask, r_mask, r_clr;

    always #5 clk = ~clk;

    intc_regfile dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .unmask_stb(unmask_stb),
        .mask_stb(mask_stb), .clr_stb(clr_stb), .int_mask(int_mask),
        .edge_sel(edge_sel), .msg_en(msg_en), .polarity(polarity),
        .in_service(in_service)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one request cycle; results captured just after the registering edge
    task automatic acc(input logic w, input logic [1:0] sz, input logic [31:0] a,
                       input logic [63:0] d);
        req_valid = 1'b1; req_write = w; req_size = sz; req_addr = a; req_wdata = d;
        @(posedge clk); #1;
        r_rsp = rsp_valid; r_rdata = rsp_rdata;
        r_unmask = unmask_stb; r_mask = mask_stb; r_clr = clr_stb;
        req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
    endtask

    task automatic t_reset;
        chk("R5 mask", int_mask, '1);
        chk("R5 edge", edge_sel, '0);
        chk("R5 msg_en", msg_en, '0);
        chk("R5 polarity", polarity, '0);
        chk("R5 in_service", in_service, '0);
        chk("R10 idle rsp", {63'd0, rsp_valid}, 64'd0);
        acc(0, B, 32'h100, '0); chk("R5 route[0]", r_rdata, 64'd1);
        acc(0, B, 32'h13F, '0); chk("R5 route[63]", r_rdata, 64'd1);
        acc(0, B, 32'h205, '0); chk("R5 vector[5]", r_rdata, 64'd0);
    endtask

    task automatic t_ids;
        acc(0, W, 32'h000, '0); chk("R6 id0", r_rdata, 64'h0001_0700);
        chk("R10 read rsp", {63'd0, r_rsp}, 64'd1);
        acc(0, W, 32'h004, '0); chk("R6 id1", r_rdata, 64'h003F_0000);
        acc(1, W, 32'h0C0, 64'hFFFF_FFFF); chk("R10 write no rsp", {63'd0, r_rsp}, 64'd0);
        acc(0, W, 32'h0C0, '0); chk("R6 reserved reads zero", r_rdata, 64'd0);
        acc(1, W, 32'h7F0, 64'hFFFF_FFFF);
        acc(0, W, 32'h7F0, '0); chk("R6 unmapped reads zero", r_rdata, 64'd0);
        chk("R6 unmapped write no effect", edge_sel | msg_en | polarity, 64'd0);
    endtask

    task automatic t_halves;
        acc(1, W, 32'h060, 64'h1234_5678);
        chk("R2 low write", edge_sel, 64'h0000_0000_1234_5678);
        acc(1, W, 32'h064, 64'hDEAD_BEEF);
        chk("R2 high write keeps low", edge_sel, 64'hDEAD_BEEF_1234_5678);
        acc(1, W, 32'h060, 64'h0);
        chk("R2 low write keeps high", edge_sel, 64'hDEAD_BEEF_0000_0000);
        acc(0, D, 32'h060, '0); chk("R3 dword read", r_rdata, 64'hDEAD_BEEF_0000_0000);
        acc(1, D, 32'h3E0, 64'hCAFE_F00D_0BAD_C0DE);
        chk("R3 dword write", polarity, 64'hCAFE_F00D_0BAD_C0DE);
        acc(0, W, 32'h3E4, '0); chk("R3 high word read", r_rdata, 64'h0000_0000_CAFE_F00D);
        acc(1, D, 32'h060, 64'h0);
        chk("R3 dword clear", edge_sel, 64'h0);
    endtask

    task automatic t_alias;
        acc(1, W, 32'h0000_A040, 64'h55);
        chk("R1 upper bits ignored on write", msg_en, 64'h55);
        acc(0, W, 32'hFFFF_F040, '0);
        chk("R1 upper bits ignored on read", r_rdata, 64'h55);
    endtask

    task automatic t_mask;
        acc(1, W, 32'h020, 64'hFFFF_0000);
        chk("R7 unmask low", r_unmask, 64'h0000_0000_0000_FFFF);
        chk("R7 no mask low", r_mask, 64'h0);
        chk("R7 mask reg", int_mask, 64'hFFFF_FFFF_FFFF_0000);
        acc(1, W, 32'h024, 64'h0000_FFFF);
        chk("R7 unmask high shifted", r_unmask, 64'hFFFF_0000_0000_0000);
        acc(1, W, 32'h020, 64'hFFFF_00FF);
        chk("R7 mask low", r_mask, 64'h0000_0000_0000_00FF);
        chk("R7 no unmask", r_unmask, 64'h0);
        @(posedge clk); #1;
        chk("R7 strobe one cycle", unmask_stb | mask_stb, 64'h0);
        acc(1, D, 32'h020, 64'h0);
        chk("R7 dword unmask", r_unmask, 64'h0000_FFFF_FFFF_00FF);
    endtask

    task automatic t_status_clear;
        acc(1, W, 32'h060, 64'hF0);
        acc(1, W, 32'h064, 64'h1);
        acc(1, W, 32'h020, 64'h0F);
        acc(1, W, 32'h3A0, 64'hFF);
        chk("R9 status write", in_service, 64'hFF);
        acc(0, W, 32'h3A0, '0); chk("R9 status read masked", r_rdata, 64'hF0);
        acc(1, W, 32'h3A4, 64'h3);
        chk("R9 status high write", in_service, 64'h3_0000_00FF);
        acc(1, W, 32'h080, 64'h3C);
        chk("R8 clear strobe edge only", r_clr, 64'h30);
        chk("R8 clear drops isr", in_service, 64'h3_0000_00CF);
        acc(0, W, 32'h080, '0); chk("R8 clear reads zero", r_rdata, 64'h0);
        acc(1, W, 32'h084, 64'h3);
        chk("R8 clear high shifted", r_clr, 64'h1_0000_0000);
        chk("R8 clear high isr", in_service, 64'h2_0000_00CF);
        acc(0, D, 32'h3A0, '0); chk("R9 dword status", r_rdata, 64'h2_0000_00C0);
    endtask

    task automatic t_tables;
        acc(1, B, 32'h10A, 64'hFFFF_FFFF_FFFF_FFA5);
        acc(0, B, 32'h10A, '0); chk("R4 route write", r_rdata, 64'hA5);
        acc(1, B, 32'h23F, 64'h5A);
        acc(0, B, 32'h23F, '0); chk("R4 vector[63]", r_rdata, 64'h5A);
        acc(1, B, 32'h240, 64'h77);
        acc(0, B, 32'h240, '0); chk("R4 vector index 64 zero", r_rdata, 64'h0);
        acc(0, B, 32'h200, '0); chk("R4 vector[0] untouched", r_rdata, 64'h0);
        acc(1, B, 32'h140, 64'h99);
        acc(0, B, 32'h140, '0); chk("R4 route index 64 zero", r_rdata, 64'h0);
        acc(0, B, 32'h100, '0); chk("R4 route[0] untouched", r_rdata, 64'h1);
        acc(1, W, 32'h100, 64'hFFFF_FFFF);
        acc(0, B, 32'h101, '0); chk("R4 word write ignored", r_rdata, 64'h1);
        acc(0, W, 32'h10A, '0); chk("R4 word read zero", r_rdata, 64'h0);
        acc(1, B, 32'h020, 64'hFF);
        chk("R4 byte write to word reg ignored", int_mask, 64'h0F);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_ids();
        t_halves();
        t_alias();
        t_mask();
        t_status_clear();
        t_tables();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule